// File: doc/BRIEF.md
# Error Status Collector with Masked Interrupt

This block gathers single-cycle error pulses from the transmit and receive datapaths. It holds each one in a sticky status bit until software clears it. Software reaches the block through a small word-addressed register port. Status bits clear by writing 1 to the bit. A mask register for each direction selects which latched errors raise the interrupt output. When the datapath reports an invalid control-plane section type, the block also records the offending 8-bit section type in a read-only log. The log is written once per error episode.

The datapaths detect the errors themselves. This block latches the pulses, masks them, logs the section type and reports the result. The register port has a one-cycle registered read path and no handshake.

Register words, by address: 0 transmit status, 1 receive status, 2 transmit mask, 3 receive mask, 4 section-type log. Addresses 5 to 7 read as zero.

Top module: `err_status_unit`

## Requirements
- R1: A pulse on `tx_err_evt[i]` sets transmit status bit i (address 0). The bits are: 0 transmit window check, 1 section-0 common FIFO overflow, 2 section-0 section FIFO overflow, 3 section-1 common FIFO overflow, 4 section-1 section FIFO overflow, 5 section-3 common FIFO overflow, 6 section-3 section FIFO overflow, 7 invalid control-plane section type. No other status bit changes.
- R2: A pulse on `rx_err_evt[i]` sets receive status bit i (address 1). The bits are: 0 receive window check, 1 bad control-plane common header, 2 bad control-plane section header, 3 bad user-plane PRB fields, 4 bad user-plane compression header, 5 errored incoming stream packet.
- R3: A status bit stays set until software clears it. Writing 0 to a status bit has no effect.
- R4: Writing 1 to a set status bit clears that bit only. Bits written with 0 keep their value.
- R5: When an error event and a write-1 clear hit the same bit in the same cycle, the bit stays set.
- R6: The receive mask (address 3) holds 6 read/write bits, and the transmit mask (address 2) holds 1 read/write bit. The unused upper bits read as 0.
- R7: `irq` is a registered signal. It is 1 exactly one cycle after a cycle in which some receive status bit i and receive mask bit i are both 1, or transmit status bit 0 and transmit mask bit 0 are both 1. Transmit status bits 1 to 7 never raise `irq`.
- R8: A transmit bit-7 event captures `sect_type` into the log (address 4, bits 7:0) only when transmit status bit 7 is 0. While bit 7 stays set, further events leave the log unchanged.
- R9: The log is read-only. Writes to address 4 have no effect.
- R10: After reset every register and `irq` are 0. Reserved bits and addresses 5 to 7 read as 0.
- R11: `reg_rdata` shows the addressed register one cycle after the address is presented. The value is the one held before that clock edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tx_err_evt | input | 8 | Transmit error event pulses |
| rx_err_evt | input | 6 | Receive error event pulses |
| sect_type | input | 8 | Section type that goes with a transmit bit-7 event |
| irq | output | 1 | Registered masked interrupt |

## Verification
A status bit that is lost or never cleared shows up on the next read of its word, one cycle after the address is presented. A wrong mask path shows on `irq` two cycles after the event pulse. The interrupt check sweeps every receive mask against every receive status pattern, so any mismatch is seen within that sweep. A log that captures at the wrong time shows a wrong section-type value on the next read of address 4.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
  localparam int TX_W     = 8;
  localparam int RX_W     = 6;
  localparam int TXM_W    = 1;
  localparam int LOG_W    = 8;
  localparam int SECT_IDX = 7;

  localparam logic [2:0] A_TX_STAT  = 3'd0;
  localparam logic [2:0] A_RX_STAT  = 3'd1;
  localparam logic [2:0] A_TX_MASK  = 3'd2;
  localparam logic [2:0] A_RX_MASK  = 3'd3;
  localparam logic [2:0] A_SECT_LOG = 3'd4;
  localparam int         LAST_ADDR  = 4;
endpackage

// File: rtl/err_sticky_word.sv
module err_sticky_word #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           stat_q[i] <= 1'b0;
      else if (set_i[i]) stat_q[i] <= 1'b1;
      else if (clr_i[i]) stat_q[i] <= 1'b0;
    end

    // R1 R2 R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> stat_q[i]);
    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_q[i] && clr_i[i] && !set_i[i]) |=> !stat_q[i]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/err_type_log.sv
module err_type_log #(
  parameter int LOG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_evt,
  input  logic             held,
  input  logic [LOG_W-1:0] sect_in,
  output logic [LOG_W-1:0] log_o
);
  logic [LOG_W-1:0] log_q;

  always_ff @(posedge clk) begin
    if (rst)                  log_q <= '0;
    else if (cap_evt && !held) log_q <= sect_in;
  end

  // R8
  log_hold_chk: assert property (@(posedge clk) disable iff (rst)
    held |=> $stable(log_q));
  // R8
  log_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && !held) |=> (log_q == $past(sect_in)));

  assign log_o = log_q;
endmodule

// File: rtl/err_reg_port.sv
module err_reg_port
  import err_stat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TX_W-1:0]   tx_stat,
  input  logic [RX_W-1:0]   rx_stat,
  input  logic [LOG_W-1:0]  log_val,
  output logic [TX_W-1:0]   tx_clr,
  output logic [RX_W-1:0]   rx_clr,
  output logic [TXM_W-1:0]  tx_mask,
  output logic [RX_W-1:0]   rx_mask,
  output logic [DATA_W-1:0] rdata
);
  logic [TXM_W-1:0]  tx_mask_q;
  logic [RX_W-1:0]   rx_mask_q;
  logic [DATA_W-1:0] rdata_q, rd_next;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:TX_W];

  assign tx_clr = (wr && addr == ADDR_W'(A_TX_STAT)) ? wdata[TX_W-1:0] : '0;
  assign rx_clr = (wr && addr == ADDR_W'(A_RX_STAT)) ? wdata[RX_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_mask_q <= '0;
      rx_mask_q <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(A_TX_MASK)) tx_mask_q <= wdata[TXM_W-1:0];
      if (addr == ADDR_W'(A_RX_MASK)) rx_mask_q <= wdata[RX_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(A_TX_STAT):  rd_next[TX_W-1:0]  = tx_stat;
      ADDR_W'(A_RX_STAT):  rd_next[RX_W-1:0]  = rx_stat;
      ADDR_W'(A_TX_MASK):  rd_next[TXM_W-1:0] = tx_mask_q;
      ADDR_W'(A_RX_MASK):  rd_next[RX_W-1:0]  = rx_mask_q;
      ADDR_W'(A_SECT_LOG): rd_next[LOG_W-1:0] = log_val;
      default:             rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(addr) > LAST_ADDR) |=> (rdata_q == '0));
  // R6
  rxmask_resv_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(A_RX_MASK)) |=> (rdata_q[DATA_W-1:RX_W] == '0));
  // R11
  read_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(A_RX_STAT)) |=> (rdata_q[RX_W-1:0] == $past(rx_stat)));

  assign tx_mask = tx_mask_q;
  assign rx_mask = rx_mask_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/err_status_unit.sv
module err_status_unit
  import err_stat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [TX_W-1:0]   tx_err_evt,
  input  logic [RX_W-1:0]   rx_err_evt,
  input  logic [LOG_W-1:0]  sect_type,
  output logic              irq
);
  logic [TX_W-1:0]  tx_stat, tx_clr;
  logic [RX_W-1:0]  rx_stat, rx_clr, rx_mask;
  logic [TXM_W-1:0] tx_mask;
  logic [LOG_W-1:0] log_val;
  logic             irq_q, any_pend;

  err_sticky_word #(.W(TX_W)) u_tx_stat (
    .clk(clk), .rst(rst), .set_i(tx_err_evt), .clr_i(tx_clr), .stat_o(tx_stat));

  err_sticky_word #(.W(RX_W)) u_rx_stat (
    .clk(clk), .rst(rst), .set_i(rx_err_evt), .clr_i(rx_clr), .stat_o(rx_stat));

  err_type_log #(.LOG_W(LOG_W)) u_log (
    .clk(clk), .rst(rst), .cap_evt(tx_err_evt[SECT_IDX]),
    .held(tx_stat[SECT_IDX]), .sect_in(sect_type), .log_o(log_val));

  err_reg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .tx_stat(tx_stat), .rx_stat(rx_stat), .log_val(log_val),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .tx_mask(tx_mask), .rx_mask(rx_mask),
    .rdata(reg_rdata));

  assign any_pend = (|(rx_stat & rx_mask)) | (|(tx_stat[TXM_W-1:0] & tx_mask));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_pend;
  end

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((|(rx_stat & rx_mask)) || (tx_stat[0] && tx_mask[0])) |=> irq_q);
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|(rx_stat & rx_mask)) && !(tx_stat[0] && tx_mask[0])) |=> !irq_q);
  // R9
  log_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(A_SECT_LOG) && !tx_err_evt[SECT_IDX]) |=> $stable(log_val));

  assign irq = irq_q;
endmodule

// File: tb/err_status_unit_test.sv
module err_status_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_err_evt = '0;
  logic [5:0]  rx_err_evt = '0;
  logic [7:0]  sect_type = '0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  err_status_unit uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_err_evt(tx_err_evt),
    .rx_err_evt(rx_err_evt), .sect_type(sect_type), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] tx, input logic [5:0] rx, input logic [7:0] st);
    tx_err_evt = tx; rx_err_evt = rx; sect_type = st;
    @(negedge clk);
    tx_err_evt = '0; rx_err_evt = '0;
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state and unmapped addresses
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); check("R10 reset/unmapped", v, 32'h0);
    end
    check("R10 irq reset", {31'b0, irq}, 32'h0);

    // R1 R3 R4 transmit bit sweep
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i), 6'h0, 8'h00);
      rd(3'd0, v); check("R1 tx bit set", v, 32'(1 << i));
      rd(3'd1, v); check("R1 rx untouched", v, 32'h0);
      wr(3'd0, 32'h0);
      rd(3'd0, v); check("R3 write 0 no effect", v, 32'(1 << i));
      wr(3'd0, 32'(1 << i));
      rd(3'd0, v); check("R4 tx clear", v, 32'h0);
    end

    // R2 R4 receive bit sweep with partial clear
    for (int i = 0; i < 6; i++) begin
      pulse(8'h0, 6'h3F, 8'h00);
      rd(3'd1, v); check("R2 rx all set", v, 32'h3F);
      wr(3'd1, 32'(1 << i));
      rd(3'd1, v); check("R4 rx single clear", v, 32'h3F & ~32'(1 << i));
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd1, v); check("R4 rx clear all", v, 32'h0);
    end

    // R5 same-cycle event and clear
    pulse(8'h0, 6'h04, 8'h00);
    reg_addr = 3'd1; reg_wr = 1'b1; reg_wdata = 32'h4; rx_err_evt = 6'h04;
    @(negedge clk);
    reg_wr = 1'b0; rx_err_evt = '0;
    rd(3'd1, v); check("R5 set wins over clear", v, 32'h4);
    wr(3'd1, 32'h3F);

    // R6 mask widths and reserved bits
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); check("R6 rx mask", v, 32'h3F);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R6 tx mask", v, 32'h1);
    wr(3'd3, 32'h15);        rd(3'd3, v); check("R6 rx mask pattern", v, 32'h15);

    // R11 read returns pre-update value
    reg_addr = 3'd1; reg_wr = 1'b0; rx_err_evt = 6'h02;
    @(negedge clk);
    rx_err_evt = '0;
    check("R11 read latency old value", reg_rdata, 32'h0);
    rd(3'd1, v); check("R11 read next value", v, 32'h2);
    wr(3'd1, 32'h3F);

    // R7 exhaustive rx mask x status sweep
    for (int m = 0; m < 64; m++) begin
      wr(3'd3, 32'(m));
      for (int s = 0; s < 64; s++) begin
        pulse(8'h0, 6'(s), 8'h00);
        @(negedge clk);
        check("R7 rx irq", {31'b0, irq}, {31'b0, |(m & s)});
        wr(3'd1, 32'h3F);
        @(negedge clk);
      end
    end
    wr(3'd3, 32'h0);

    // R7 transmit sources with both mask values
    for (int tm = 0; tm < 2; tm++) begin
      wr(3'd2, 32'(tm));
      for (int i = 0; i < 8; i++) begin
        pulse(8'(1 << i), 6'h0, 8'h00);
        @(negedge clk);
        check("R7 tx irq", {31'b0, irq}, {31'b0, (i == 0) && (tm == 1)});
        wr(3'd0, 32'hFF);
        @(negedge clk);
      end
    end

    // R8 log capture and hold, R9 read-only
    pulse(8'h80, 6'h0, 8'h5A);
    rd(3'd4, v); check("R8 first capture", v, 32'h5A);
    pulse(8'h80, 6'h0, 8'h33);
    rd(3'd4, v); check("R8 hold while set", v, 32'h5A);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R9 log read-only", v, 32'h5A);
    wr(3'd0, 32'h80);
    rd(3'd4, v); check("R8 value kept after clear", v, 32'h5A);
    pulse(8'h80, 6'h0, 8'hC4);
    rd(3'd4, v); check("R8 recapture", v, 32'hC4);
    rd(3'd0, v); check("R1 bit7 set by log event", v, 32'h80);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule